// File: doc/BRIEF.md
# Layered State-Enable Register and Access Guard

This block keeps the three state-enable registers of register index 0: a 64-bit machine-level register, a 64-bit hypervisor-level register and a 32-bit supervisor-level register. Four such registers are allowed per level; only index 0 lives here. Each level is filtered by the level above it. Stored values are masked on write and effective values are masked on read. A machine bit that is hard-wired or cleared to zero cannot show up as one further down.

The same register contents drive a combinational access guard. For an access request from the current privilege mode and virtualization state, the guard reports one of three outcomes: allowed, illegal-instruction fault, or virtual-instruction fault. The request names the controlled state class and, for indirect alias registers, the selector value of the indirect window. The outcome depends on which level refused the access. The extension state itself, instruction decode and trap delivery are handled elsewhere.

The control bits sit at fixed positions:
- bit 1: floating-point control/status access when floating point runs on integer registers
- bit 54: control-transfer-record state
- bit 58: guest interrupt-file state

Top module: `stateen_guard`

## Requirements
- R1: After reset all three registers hold zero. Every register select reads 0, and a gated request from S-mode is refused.
- R2: A machine write keeps only the implemented bits (default bits 0, 1, 54, 58). While misa_f is 1, bit 1 is forced to zero: it cannot be written and reads back as 0.
- R3: A hypervisor read (csr_sel 1) returns the stored value ANDed with the effective machine value. A hypervisor write stores only the bits that are effective in the machine register at that time.
- R4: A supervisor read (csr_sel 2) returns the low 32 bits ANDed with the machine value, zero-extended. When virt is 1, the result is also ANDed with the hypervisor value. Writes are masked the same way.
- R5: A request made in M-mode (priv 2'b11) is always allowed.
- R6: A gated request from S (2'b01) or U (2'b00) whose machine bit is zero raises illegal-instruction, for either value of virt.
- R7: When virt is 1 and the machine bit is set but the hypervisor bit is zero, the result is virtual-instruction. When virt is 0, the hypervisor register is ignored.
- R8: The supervisor register gates only U-mode requests, and only for bits below 32. A refusal by this register gives illegal-instruction when virt is 0 and virtual-instruction when virt is 1.
- R9: The floating-point class (acc_class 1) is gated by bit 1 only while misa_f is 0. While misa_f is 1 it is always allowed.
- R10: The indirect-alias class (acc_class 3) is gated by bit 54 only for selector values 0x200 through 0x2FF. Outside that range it is allowed. Class 2 is gated by bit 54, class 4 by bit 58, and class 0 is never gated.
- R11: Exactly one of acc_ok, acc_illegal, acc_virtual is high at all times.
- R12: A write takes effect at the next rising clock edge. Reads and guard outputs follow register and request inputs without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_sel | input | 2 | Register select: 0 machine, 1 hypervisor, 2 supervisor, 3 none |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Effective value of the selected register |
| priv | input | 2 | Current mode: 2'b11 M, 2'b01 S, 2'b00 U |
| virt | input | 1 | Virtualization state |
| misa_f | input | 1 | Floating-point registers present |
| isel | input | 12 | Indirect window selector value |
| acc_class | input | 3 | Request class: 0 none, 1 FP, 2 transfer record, 3 indirect alias, 4 interrupt file |
| acc_ok | output | 1 | Request allowed |
| acc_illegal | output | 1 | Illegal-instruction fault |
| acc_virtual | output | 1 | Virtual-instruction fault |

## Verification
Register writes are due one edge after the strobe. Reads and guard outputs are combinational and are due in the same cycle as their inputs. The bench drives every input on the falling edge. A write is held across exactly one rising edge and released on the next falling edge. Every sample is taken 1 ns after a falling-edge drive, so each check sees fully settled combinational results and the post-write register state, well away from the rising edge.

// File: rtl/stateen_pkg.sv
package stateen_pkg;

   typedef enum logic [1:0] {
      PRV_U = 2'b00,
      PRV_S = 2'b01,
      PRV_M = 2'b11
   } priv_e;

   typedef enum logic [2:0] {
      CLS_NONE  = 3'd0,
      CLS_FP    = 3'd1,
      CLS_XFER  = 3'd2,
      CLS_ALIAS = 3'd3,
      CLS_IFILE = 3'd4
   } acc_cls_e;

   typedef enum logic [1:0] {
      SEL_MACH = 2'd0,
      SEL_HYP  = 2'd1,
      SEL_SUP  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int unsigned FCSR_BIT  = 1;
   localparam int unsigned XFER_BIT  = 54;
   localparam int unsigned IFILE_BIT = 58;

   localparam logic [11:0] ALIAS_LO = 12'h200;
   localparam logic [11:0] ALIAS_HI = 12'h2FF;

endpackage

// File: rtl/stateen_level.sv
module stateen_level #(
   parameter int unsigned W        = 64,
   parameter logic [W-1:0] WRITABLE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] wmask,
   output logic [W-1:0] q
);

   generate
      if (W < 1 || W > 64) begin : g_bad_width
         $error("stateen_level: W must be 1..64");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & wmask & WRITABLE;
   end

   // R12: a write lands at the next edge, filtered by the parent mask
   a_r12_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == ($past(wdata) & $past(wmask) & WRITABLE)));

   // R12: without a write the stored value holds
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/stateen_access.sv
module stateen_access
   import stateen_pkg::*;
#(
   parameter int unsigned MW = 64,
   parameter int unsigned SW = 32
) (
   input  logic [MW-1:0] m_eff,
   input  logic [MW-1:0] h_eff,
   input  logic [SW-1:0] s_eff,
   input  logic [1:0]    priv,
   input  logic          virt,
   input  logic          misa_f,
   input  logic [11:0]   isel,
   input  logic [2:0]    acc_class,
   output logic          acc_ok,
   output logic          acc_illegal,
   output logic          acc_virtual
);

   localparam int unsigned IW = $clog2(MW);
   localparam int unsigned SIW = (SW > 1) ? $clog2(SW) : 1;

   logic          gated;
   logic [IW-1:0] idx;
   logic          m_pass, h_pass, s_pass;
   priv_e         pv;

   assign pv = priv_e'(priv);

   always_comb begin
      gated = 1'b0;
      idx   = '0;
      case (acc_cls_e'(acc_class))
         CLS_FP: begin
            gated = !misa_f;
            idx   = IW'(FCSR_BIT);
         end
         CLS_XFER: begin
            gated = 1'b1;
            idx   = IW'(XFER_BIT);
         end
         CLS_ALIAS: begin
            gated = (isel >= ALIAS_LO) && (isel <= ALIAS_HI);
            idx   = IW'(XFER_BIT);
         end
         CLS_IFILE: begin
            gated = 1'b1;
            idx   = IW'(IFILE_BIT);
         end
         default: begin
            gated = 1'b0;
            idx   = '0;
         end
      endcase
   end

   always_comb begin
      m_pass = m_eff[idx];
      h_pass = !virt || h_eff[idx];
      if (pv != PRV_U || 32'(idx) >= SW) s_pass = 1'b1;
      else                               s_pass = s_eff[idx[SIW-1:0]];
   end

   always_comb begin
      acc_ok      = 1'b0;
      acc_illegal = 1'b0;
      acc_virtual = 1'b0;
      if (!gated || pv == PRV_M) acc_ok = 1'b1;
      else if (!m_pass)          acc_illegal = 1'b1;
      else if (!h_pass)          acc_virtual = 1'b1;
      else if (!s_pass) begin
         if (virt) acc_virtual = 1'b1;
         else      acc_illegal = 1'b1;
      end
      else acc_ok = 1'b1;
   end

   // R11: the outcome is always one-hot
   always_comb begin
      a_r11_onehot_comb: assert ($countones({acc_ok, acc_illegal, acc_virtual}) == 1 || $isunknown(priv));
   end

endmodule

// File: rtl/stateen_guard.sv
module stateen_guard
   import stateen_pkg::*;
#(
   parameter int unsigned MW          = 64,
   parameter int unsigned SW          = 32,
   parameter logic [63:0] M_WRITABLE  = 64'h0440_0000_0000_0003,
   parameter bit          HAS_HYP     = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        csr_we,
   input  logic [1:0]  csr_sel,
   input  logic [63:0] csr_wdata,
   output logic [63:0] csr_rdata,
   input  logic [1:0]  priv,
   input  logic        virt,
   input  logic        misa_f,
   input  logic [11:0] isel,
   input  logic [2:0]  acc_class,
   output logic        acc_ok,
   output logic        acc_illegal,
   output logic        acc_virtual
);

   generate
      if (MW != 64)
         begin : g_bad_mw   $error("stateen_guard: MW must be 64"); end
      if (SW < 2 || SW > MW)
         begin : g_bad_sw   $error("stateen_guard: SW must be 2..MW"); end
      if (IFILE_BIT >= MW || XFER_BIT >= MW)
         begin : g_bad_bits $error("stateen_guard: control bit out of range"); end
   endgenerate

   logic [MW-1:0] fcsr_kill;
   logic [MW-1:0] m_q, m_wmask, m_eff;
   logic [MW-1:0] h_q, h_eff;
   logic [SW-1:0] s_q, s_wmask, s_eff, s_rd;
   logic [SW-1:0] h_low;
   logic          we_m, we_h, we_s;

   assign we_m = csr_we && (reg_sel_e'(csr_sel) == SEL_MACH);
   assign we_h = csr_we && (reg_sel_e'(csr_sel) == SEL_HYP);
   assign we_s = csr_we && (reg_sel_e'(csr_sel) == SEL_SUP);

   assign fcsr_kill = misa_f ? (MW'(1) << FCSR_BIT) : '0;
   assign m_wmask   = ~fcsr_kill;

   stateen_level #(.W(MW), .WRITABLE(M_WRITABLE[MW-1:0])) u_mach (
      .clk(clk), .rst_n(rst_n), .we(we_m),
      .wdata(csr_wdata[MW-1:0]), .wmask(m_wmask), .q(m_q)
   );

   assign m_eff = m_q & ~fcsr_kill;

   generate
      if (HAS_HYP) begin : g_hyp
         stateen_level #(.W(MW), .WRITABLE(M_WRITABLE[MW-1:0])) u_hyp (
            .clk(clk), .rst_n(rst_n), .we(we_h),
            .wdata(csr_wdata[MW-1:0]), .wmask(m_eff), .q(h_q)
         );
      end else begin : g_no_hyp
         assign h_q = '0;
      end
   endgenerate

   assign h_eff   = h_q & m_eff;
   assign h_low   = virt ? h_eff[SW-1:0] : '1;
   assign s_wmask = m_eff[SW-1:0] & h_low;

   stateen_level #(.W(SW), .WRITABLE(M_WRITABLE[SW-1:0])) u_sup (
      .clk(clk), .rst_n(rst_n), .we(we_s),
      .wdata(csr_wdata[SW-1:0]), .wmask(s_wmask), .q(s_q)
   );

   assign s_eff = s_q & m_eff[SW-1:0];
   assign s_rd  = s_eff & h_low;

   always_comb begin
      case (reg_sel_e'(csr_sel))
         SEL_MACH: csr_rdata = 64'(m_eff);
         SEL_HYP:  csr_rdata = 64'(h_eff);
         SEL_SUP:  csr_rdata = 64'(s_rd);
         default:  csr_rdata = '0;
      endcase
   end

   stateen_access #(.MW(MW), .SW(SW)) u_access (
      .m_eff(m_eff), .h_eff(h_eff), .s_eff(s_eff),
      .priv(priv), .virt(virt), .misa_f(misa_f), .isel(isel),
      .acc_class(acc_class),
      .acc_ok(acc_ok), .acc_illegal(acc_illegal), .acc_virtual(acc_virtual)
   );

   // R11: outcome one-hot at every edge
   a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({acc_ok, acc_illegal, acc_virtual}));

   // R5: machine mode never refused
   a_r5_machine_free: assert property (@(posedge clk) disable iff (!rst_n)
      (priv == 2'b11) |-> acc_ok);

   // R9: with floating-point registers present, FP class is never refused
   a_r9_fp_free: assert property (@(posedge clk) disable iff (!rst_n)
      (misa_f && acc_class == 3'd1) |-> acc_ok);

   // R2: the FCSR enable never reads as one from any level while misa_f is set
   a_r2_fcsr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      misa_f |-> !csr_rdata[FCSR_BIT]);

   // R3: a hypervisor bit never reads as one without its machine bit
   a_r3_hyp_under_mach: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_sel == 2'd1) |-> ((csr_rdata[MW-1:0] & ~m_q) == '0));

   // R10: alias class outside the window is never refused
   a_r10_alias_window: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_class == 3'd3 && (isel < 12'h200 || isel > 12'h2FF)) |-> acc_ok);

endmodule

// File: tb/stateen_guard_tb.sv
module stateen_guard_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [1:0]  csr_sel = 2'd3;
   logic [63:0] csr_wdata = '0;
   logic [63:0] csr_rdata;
   logic [1:0]  priv = 2'b11;
   logic        virt = 1'b0;
   logic        misa_f = 1'b0;
   logic [11:0] isel = '0;
   logic [2:0]  acc_class = '0;
   logic        acc_ok, acc_illegal, acc_virtual;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   stateen_guard u_dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .priv(priv), .virt(virt),
      .misa_f(misa_f), .isel(isel), .acc_class(acc_class),
      .acc_ok(acc_ok), .acc_illegal(acc_illegal), .acc_virtual(acc_virtual)
   );

   // outcome code: 0 allowed, 1 illegal, 2 virtual
   typedef struct packed {
      logic [3:0]  req;
      logic [1:0]  pr;
      logic        v;
      logic        f;
      logic [2:0]  cls;
      logic [11:0] sel;
      logic [1:0]  exp;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{4'd5,  2'b11, 1'b0, 1'b0, 3'd1, 12'h000, 2'd0}, // R5 machine
      '{4'd8,  2'b01, 1'b0, 1'b0, 3'd1, 12'h000, 2'd0}, // R8 S ignores sup reg
      '{4'd8,  2'b00, 1'b0, 1'b0, 3'd1, 12'h000, 2'd1}, // R8 U, V=0 -> illegal
      '{4'd8,  2'b00, 1'b1, 1'b0, 3'd1, 12'h000, 2'd2}, // R8 VU -> virtual
      '{4'd7,  2'b01, 1'b1, 1'b0, 3'd2, 12'h000, 2'd2}, // R7 hyp bit54 clear
      '{4'd7,  2'b01, 1'b0, 1'b0, 3'd2, 12'h000, 2'd0}, // R7 hyp ignored V=0
      '{4'd10, 2'b01, 1'b1, 1'b0, 3'd4, 12'h000, 2'd0}, // R10 bit58 set
      '{4'd9,  2'b00, 1'b1, 1'b1, 3'd1, 12'h000, 2'd0}, // R9 misa_f=1
      '{4'd10, 2'b01, 1'b1, 1'b0, 3'd3, 12'h200, 2'd2}, // R10 window low
      '{4'd10, 2'b01, 1'b1, 1'b0, 3'd3, 12'h2FF, 2'd2}, // R10 window high
      '{4'd10, 2'b01, 1'b1, 1'b0, 3'd3, 12'h300, 2'd0}, // R10 above window
      '{4'd10, 2'b01, 1'b1, 1'b0, 3'd3, 12'h1FF, 2'd0}, // R10 below window
      '{4'd10, 2'b01, 1'b1, 1'b0, 3'd0, 12'h000, 2'd0}, // R10 class none
      '{4'd8,  2'b00, 1'b0, 1'b0, 3'd2, 12'h000, 2'd0}, // R8 bit54 beyond sup
      '{4'd9,  2'b01, 1'b1, 1'b0, 3'd1, 12'h000, 2'd0}  // R9 hyp bit1 set
   };

   function automatic logic [1:0] outcome();
      return acc_virtual ? 2'd2 : (acc_illegal ? 2'd1 : 2'd0);
   endfunction

   task automatic chk_rd(input string tag, input logic [63:0] exp);
      checks++;
      if (csr_rdata !== exp) begin
         errors++;
         $display("FAIL %s rdata actual %h expected %h", tag, csr_rdata, exp);
      end
   endtask

   task automatic chk_acc(input string tag, input logic [1:0] exp);
      checks++;
      if ({acc_ok, acc_illegal, acc_virtual} != {exp == 2'd0, exp == 2'd1, exp == 2'd2}) begin
         errors++;
         $display("FAIL %s outcome actual %0d expected %0d (ok%b il%b vi%b)",
                  tag, outcome(), exp, acc_ok, acc_illegal, acc_virtual);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [63:0] d);
      @(negedge clk);
      csr_sel = s; csr_wdata = d; csr_we = 1'b1;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, input logic [1:0] p, input logic v);
      @(negedge clk);
      csr_sel = s; priv = p; virt = v;
      #1;
   endtask

   task automatic req(input logic [1:0] p, input logic v, input logic [2:0] c, input logic [11:0] s);
      @(negedge clk);
      priv = p; virt = v; acc_class = c; isel = s;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         checks++; errors++;
         $display("FAIL R12 watchdog actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(2'd0, 2'b01, 1'b0); chk_rd("R1 mach", 64'h0);
      rd(2'd1, 2'b01, 1'b0); chk_rd("R1 hyp", 64'h0);
      rd(2'd2, 2'b01, 1'b0); chk_rd("R1 sup", 64'h0);
      req(2'b01, 1'b0, 3'd2, 12'h0); chk_acc("R1 S refused", 2'd1);

      // R2: forced-zero FCSR bit and implemented mask
      misa_f = 1'b1;
      wr(2'd0, '1);
      rd(2'd0, 2'b01, 1'b0); chk_rd("R2 mach f=1", 64'h0440_0000_0000_0001);
      wr(2'd1, '1); // R3: bit1 absent from machine, must not be stored
      misa_f = 1'b0;
      rd(2'd0, 2'b01, 1'b0); chk_rd("R2 mach write masked", 64'h0440_0000_0000_0001);
      wr(2'd0, '1);
      rd(2'd0, 2'b01, 1'b0); chk_rd("R2 mach f=0", 64'h0440_0000_0000_0003);
      rd(2'd1, 2'b01, 1'b0); chk_rd("R3 hyp write masked", 64'h0440_0000_0000_0001);
      misa_f = 1'b1;
      rd(2'd0, 2'b01, 1'b0); chk_rd("R2 mach read forced", 64'h0440_0000_0000_0001);
      misa_f = 1'b0;

      // R4: supervisor masking
      wr(2'd1, 64'h0400_0000_0000_0002);
      rd(2'd1, 2'b01, 1'b0); chk_rd("R3 hyp", 64'h0400_0000_0000_0002);
      rd(2'd2, 2'b01, 1'b0);
      wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(2'd2, 2'b01, 1'b0); chk_rd("R4 sup V=0", 64'h3);
      rd(2'd2, 2'b01, 1'b1); chk_rd("R4 sup VS", 64'h2);
      rd(2'd2, 2'b01, 1'b0);
      wr(2'd2, 64'h1);
      rd(2'd2, 2'b01, 1'b0); chk_rd("R4 sup rewrite", 64'h1);

      // Table walk: m=bits0,1,54,58  h=bits1,58  s=bit0
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         priv = VECS[i].pr; virt = VECS[i].v; misa_f = VECS[i].f;
         acc_class = VECS[i].cls; isel = VECS[i].sel;
         #1;
         chk_acc($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp);
      end
      misa_f = 1'b0;

      // R6: machine refusal is illegal even when V=1
      wr(2'd0, 64'h0);
      req(2'b01, 1'b1, 3'd2, 12'h0);  chk_acc("R6 VS machine refusal", 2'd1);
      req(2'b00, 1'b0, 3'd1, 12'h0);  chk_acc("R6 U machine refusal", 2'd1);
      req(2'b11, 1'b0, 3'd4, 12'h0);  chk_acc("R5 M with zero regs", 2'd0);
      rd(2'd1, 2'b01, 1'b0); chk_rd("R3 hyp hidden", 64'h0);
      wr(2'd0, '1);
      rd(2'd1, 2'b01, 1'b0); chk_rd("R3 hyp retained", 64'h0400_0000_0000_0002);
      rd(2'd3, 2'b01, 1'b0); chk_rd("R12 no select", 64'h0);

      finish_run();
   end

endmodule